// File: doc/BRIEF.md
# Scannable Control and Observe Test-Point Cluster

This block is a set of test points placed on functional nets to make them easier to test. It has four kinds of control point. Each control point sits between a functional input and its output. A constant-low point and a constant-high point override their net with a fixed value whenever test mode is on. A register-driven point overrides its net with a bit held in a scannable control register. A gated point overrides its net with a control-register bit only when test mode is on and its scannable enable bit is also set. Observe points fold groups of internal nets with XOR into scannable observe registers. A tester can then read them out.

All test-point registers sit on one dedicated test clock. They form a single serial chain from `scan_in` to `scan_out`. The order is: the enable registers, then the control registers, then the observe registers. While `scan_enable` is high the chain shifts by one bit per clock. While it is low, control and enable registers hold their value and observe registers capture. The sharing ratios are parameters: how many points use one control register, one enable register, and one observe register. Every point count must be at least 1. The pins are plain level signals with no valid/ready handshake. Serial data moves one bit per test clock, and there is no back-pressure.

Top module: `tp_cluster`

## Requirements
- R1: An active-low asynchronous reset clears every enable, control and observe register. After reset `scan_out` is 0 and every gated point passes its input through.
- R2: With `test_mode` high, every bit of `f0_dout` is 0 and every bit of `f1_dout` is 1, whatever the inputs.
- R3: With `test_mode` high, register-driven point i outputs control register bit floor(i / CTL_SHARE).
- R4: Gated point j outputs control register bit floor((NFR + j) / CTL_SHARE) only when `test_mode` is high and enable register bit floor(j / TPE_SHARE) is 1. In every other case it passes `ct_din[j]`.
- R5: When `scan_enable` is high, each test-clock edge shifts the chain by one position. Chain position 0 takes `scan_in`. Positions 0..NTE-1 are the enable registers, then NCR control registers, then NOR observe registers. `scan_out` is the last position.
- R6: When `scan_enable` is low, each edge loads observe register g with the XOR of `obs_net[g*OBS_SHARE +: OBS_SHARE]` (only bits that exist are included). Enable and control registers keep their value.
- R7: One control register drives up to CTL_SHARE points and one enable register gates up to TPE_SHARE points. Register-driven points come first in the control numbering, followed by the gated points.
- R8: While the chain shifts, the present control-register bits keep being applied to enabled points, bit by bit as they change.
- R9: With `test_mode` low, every output equals its input, whatever the registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tp_clk | input | 1 | Dedicated test-point clock |
| tp_rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | Global test-mode enable for control points |
| scan_enable | input | 1 | High: shift; low: capture/hold |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output |
| f0_din | input | NF0 | Nets under constant-low points |
| f0_dout | output | NF0 | Outputs of constant-low points |
| f1_din | input | NF1 | Nets under constant-high points |
| f1_dout | output | NF1 | Outputs of constant-high points |
| fr_din | input | NFR | Nets under register-driven points |
| fr_dout | output | NFR | Outputs of register-driven points |
| ct_din | input | NCT | Nets under gated points |
| ct_dout | output | NCT | Outputs of gated points |
| obs_net | input | NOB | Internal nets being observed |

## Verification
The hardest situation to reach from the ports combines two things. The gated points must be checked under a mix of enabled and disabled bits. At the same point the two control registers must hold different values. Only a full serial load puts the chain in that state, so the stimulus shifts in whole chain images and then checks each gated output against the image. To check that overrides stay live during shifting, the stimulus watches a register-driven output on every shift cycle. Observe captures use net patterns whose XOR groups differ. They are then unloaded through a scoreboard while the next image is shifted in.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // number of registers needed to serve n points at 'per' points each
  function automatic int groups(int n, int per);
    return (n + per - 1) / per;
  endfunction
endpackage

// File: rtl/tp_scan_reg.sv
module tp_scan_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         se,
  input  logic         sin,
  input  logic [W-1:0] func_d,
  output logic [W-1:0] q,
  output logic         sout
);
  logic [W:0] ser;
  assign ser  = {q, sin};
  assign sout = q[W-1];

  for (genvar i = 0; i < W; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (se) q[i] <= ser[i];
      else         q[i] <= func_d[i];
    end
  end
endmodule

// File: rtl/tp_point_mux.sv
module tp_point_mux #(
  parameter int N = 4
) (
  input  logic [N-1:0] din,
  input  logic [N-1:0] en,
  input  logic [N-1:0] tv,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_pt
    assign dout[i] = en[i] ? tv[i] : din[i];
  end
endmodule

// File: rtl/tp_obs_fold.sv
module tp_obs_fold #(
  parameter int NNET  = 12,
  parameter int SHARE = 8,
  parameter int NREG  = 2
) (
  input  logic [NNET-1:0] net,
  output logic [NREG-1:0] fold
);
  localparam int PW = NREG * SHARE;
  logic [PW-1:0] padded;

  always_comb begin
    padded = '0;
    padded[NNET-1:0] = net;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_grp
    assign fold[g] = ^padded[g*SHARE +: SHARE];
  end
endmodule

// File: rtl/tp_cluster.sv
module tp_cluster #(
  parameter int NF0       = 2,
  parameter int NF1       = 2,
  parameter int NFR       = 4,
  parameter int NCT       = 6,
  parameter int NOB       = 12,
  parameter int CTL_SHARE = 8,
  parameter int TPE_SHARE = 1,
  parameter int OBS_SHARE = 8
) (
  input  logic           tp_clk,
  input  logic           tp_rst_n,
  input  logic           test_mode,
  input  logic           scan_enable,
  input  logic           scan_in,
  output logic           scan_out,
  input  logic [NF0-1:0] f0_din,
  output logic [NF0-1:0] f0_dout,
  input  logic [NF1-1:0] f1_din,
  output logic [NF1-1:0] f1_dout,
  input  logic [NFR-1:0] fr_din,
  output logic [NFR-1:0] fr_dout,
  input  logic [NCT-1:0] ct_din,
  output logic [NCT-1:0] ct_dout,
  input  logic [NOB-1:0] obs_net
);
  localparam int NTE = tp_pkg::groups(NCT, TPE_SHARE);
  localparam int NCR = tp_pkg::groups(NFR + NCT, CTL_SHARE);
  localparam int NOR = tp_pkg::groups(NOB, OBS_SHARE);
  localparam int L   = NTE + NCR + NOR;

  logic [NTE-1:0] tpe_q;
  logic [NCR-1:0] ctl_q;
  logic [NOR-1:0] obs_q;
  logic [NOR-1:0] obs_fold;
  logic           tpe_so, ctl_so;
  logic [L-1:0]   chain;

  assign chain = {obs_q, ctl_q, tpe_q};

  // chain: scan_in -> enable regs -> control regs -> observe regs -> scan_out
  tp_scan_reg #(.W(NTE)) u_tpe (
    .clk(tp_clk), .rst_n(tp_rst_n), .se(scan_enable), .sin(scan_in),
    .func_d(tpe_q), .q(tpe_q), .sout(tpe_so));

  tp_scan_reg #(.W(NCR)) u_ctl (
    .clk(tp_clk), .rst_n(tp_rst_n), .se(scan_enable), .sin(tpe_so),
    .func_d(ctl_q), .q(ctl_q), .sout(ctl_so));

  tp_obs_fold #(.NNET(NOB), .SHARE(OBS_SHARE), .NREG(NOR)) u_fold (
    .net(obs_net), .fold(obs_fold));

  tp_scan_reg #(.W(NOR)) u_obs (
    .clk(tp_clk), .rst_n(tp_rst_n), .se(scan_enable), .sin(ctl_so),
    .func_d(obs_fold), .q(obs_q), .sout(scan_out));

  // constant points
  tp_point_mux #(.N(NF0)) u_f0 (
    .din(f0_din), .en({NF0{test_mode}}), .tv({NF0{1'b0}}), .dout(f0_dout));
  tp_point_mux #(.N(NF1)) u_f1 (
    .din(f1_din), .en({NF1{test_mode}}), .tv({NF1{1'b1}}), .dout(f1_dout));

  // register-driven points: control index i
  logic [NFR-1:0] fr_tv;
  for (genvar i = 0; i < NFR; i++) begin : g_fr
    assign fr_tv[i] = ctl_q[i / CTL_SHARE];
  end
  tp_point_mux #(.N(NFR)) u_fr (
    .din(fr_din), .en({NFR{test_mode}}), .tv(fr_tv), .dout(fr_dout));

  // gated points: control index NFR + j, enable index j / TPE_SHARE
  logic [NCT-1:0] ct_tv, ct_en;
  for (genvar j = 0; j < NCT; j++) begin : g_ct
    assign ct_tv[j] = ctl_q[(NFR + j) / CTL_SHARE];
    assign ct_en[j] = test_mode & tpe_q[j / TPE_SHARE];
  end
  tp_point_mux #(.N(NCT)) u_ct (
    .din(ct_din), .en(ct_en), .tv(ct_tv), .dout(ct_dout));
endmodule

// File: rtl/tp_cluster_chk.sv
module tp_cluster_chk #(
  parameter int NF0       = 2,
  parameter int NF1       = 2,
  parameter int NFR       = 4,
  parameter int NCT       = 6,
  parameter int NOB       = 12,
  parameter int CTL_SHARE = 8,
  parameter int TPE_SHARE = 1,
  parameter int OBS_SHARE = 8,
  parameter int L         = 10
) (
  input logic           tp_clk,
  input logic           tp_rst_n,
  input logic           test_mode,
  input logic           scan_enable,
  input logic           scan_in,
  input logic [NF0-1:0] f0_din,
  input logic [NF0-1:0] f0_dout,
  input logic [NF1-1:0] f1_din,
  input logic [NF1-1:0] f1_dout,
  input logic [NFR-1:0] fr_din,
  input logic [NFR-1:0] fr_dout,
  input logic [NCT-1:0] ct_din,
  input logic [NCT-1:0] ct_dout,
  input logic [NOB-1:0] obs_net,
  input logic [L-1:0]   chain
);
  localparam int NTE = tp_pkg::groups(NCT, TPE_SHARE);
  localparam int NCR = tp_pkg::groups(NFR + NCT, CTL_SHARE);
  localparam int G0  = (OBS_SHARE < NOB) ? OBS_SHARE : NOB;
  localparam int HW  = NTE + NCR;

  AST_FORCE_LOW: assert property (@(posedge tp_clk) disable iff (!tp_rst_n)
    test_mode |-> f0_dout == '0); // R2
  AST_FORCE_HIGH: assert property (@(posedge tp_clk) disable iff (!tp_rst_n)
    test_mode |-> f1_dout == '1); // R2
  AST_BYPASS: assert property (@(posedge tp_clk) disable iff (!tp_rst_n)
    !test_mode |-> (f0_dout == f0_din && f1_dout == f1_din &&
                    fr_dout == fr_din && ct_dout == ct_din)); // R9
  AST_SHIFT_IN: assert property (@(posedge tp_clk) disable iff (!tp_rst_n)
    scan_enable |=> chain[0] == $past(scan_in)); // R5
  AST_HOLD_CTRL: assert property (@(posedge tp_clk) disable iff (!tp_rst_n)
    !scan_enable |=> chain[HW-1:0] == $past(chain[HW-1:0])); // R6
  AST_OBS_CAPTURE: assert property (@(posedge tp_clk) disable iff (!tp_rst_n)
    !scan_enable |=> chain[HW] == $past(^obs_net[G0-1:0])); // R6

  for (genvar j = 0; j < NCT; j++) begin : g_dis
    AST_GATE_OFF: assert property (@(posedge tp_clk) disable iff (!tp_rst_n)
      !chain[j / TPE_SHARE] |-> ct_dout[j] == ct_din[j]); // R4
  end
endmodule

bind tp_cluster tp_cluster_chk #(
  .NF0(NF0), .NF1(NF1), .NFR(NFR), .NCT(NCT), .NOB(NOB),
  .CTL_SHARE(CTL_SHARE), .TPE_SHARE(TPE_SHARE), .OBS_SHARE(OBS_SHARE), .L(L)
) u_chk (
  .tp_clk(tp_clk), .tp_rst_n(tp_rst_n), .test_mode(test_mode),
  .scan_enable(scan_enable), .scan_in(scan_in),
  .f0_din(f0_din), .f0_dout(f0_dout), .f1_din(f1_din), .f1_dout(f1_dout),
  .fr_din(fr_din), .fr_dout(fr_dout), .ct_din(ct_din), .ct_dout(ct_dout),
  .obs_net(obs_net), .chain(chain)
);

// File: tb/tp_cluster_test.sv
module tp_cluster_test;
  localparam int PERIOD = 10;
  localparam int NF0 = 2, NF1 = 2, NFR = 4, NCT = 6, NOB = 12;
  localparam int CS = 8, TS = 1, OS = 8;
  localparam int NTE = (NCT + TS - 1) / TS;
  localparam int NCR = (NFR + NCT + CS - 1) / CS;
  localparam int NOR = (NOB + OS - 1) / OS;
  localparam int L = NTE + NCR + NOR;

  logic tp_clk = 0, tp_rst_n = 0, test_mode = 0, scan_enable = 0, scan_in = 0;
  logic scan_out;
  logic [NF0-1:0] f0_din = '0, f0_dout;
  logic [NF1-1:0] f1_din = '0, f1_dout;
  logic [NFR-1:0] fr_din = '0, fr_dout;
  logic [NCT-1:0] ct_din = '0, ct_dout;
  logic [NOB-1:0] obs_net = '0;

  int total = 0, bad = 0;
  logic [L-1:0] model = '0;   // bench image of the chain, bit 0 nearest scan_in
  bit exp_q[$];
  event sample_ev;

  always #(PERIOD/2) tp_clk = ~tp_clk;

  tp_cluster #(.NF0(NF0), .NF1(NF1), .NFR(NFR), .NCT(NCT), .NOB(NOB),
    .CTL_SHARE(CS), .TPE_SHARE(TS), .OBS_SHARE(OS)) uut (
    .tp_clk(tp_clk), .tp_rst_n(tp_rst_n), .test_mode(test_mode),
    .scan_enable(scan_enable), .scan_in(scan_in), .scan_out(scan_out),
    .f0_din(f0_din), .f0_dout(f0_dout), .f1_din(f1_din), .f1_dout(f1_dout),
    .fr_din(fr_din), .fr_dout(fr_dout), .ct_din(ct_din), .ct_dout(ct_dout),
    .obs_net(obs_net));

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops one expected scan_out bit per sample event
  always @(sample_ev) begin
    if (exp_q.size() == 0) check(0, "R5 empty queue", 0, 0);
    else begin
      automatic bit e = exp_q.pop_front();
      check(scan_out == e, "R5 scan_out", 32'(scan_out), 32'(e));
    end
  end

  function automatic logic [NCT-1:0] ct_expect(logic [L-1:0] m);
    logic [NCT-1:0] r;
    for (int j = 0; j < NCT; j++)
      r[j] = (test_mode && m[j / TS]) ? m[NTE + (NFR + j) / CS] : ct_din[j];
    return r;
  endfunction

  function automatic logic [NFR-1:0] fr_expect(logic [L-1:0] m);
    logic [NFR-1:0] r;
    for (int i = 0; i < NFR; i++) r[i] = test_mode ? m[NTE + i / CS] : fr_din[i];
    return r;
  endfunction

  // driver: shifts in image v (v[L-1] first), pushes expected outgoing bits
  task automatic shift_image(logic [L-1:0] v);
    for (int t = L - 1; t >= 0; t--) begin
      @(negedge tp_clk);
      scan_enable = 1; scan_in = v[t];
      #(PERIOD/4);
      exp_q.push_back(model[L-1]);
      ->sample_ev;
      check(fr_dout == fr_expect(model), "R8 live override", 32'(fr_dout), 32'(fr_expect(model)));
      @(posedge tp_clk);
      model = {model[L-2:0], v[t]};
    end
  endtask

  task automatic capture(logic [NOB-1:0] nets);
    @(negedge tp_clk);
    scan_enable = 0; obs_net = nets;
    @(posedge tp_clk);
    for (int g = 0; g < NOR; g++) begin
      automatic logic x = 0;
      for (int i = 0; i < OS; i++) if (g * OS + i < NOB) x ^= nets[g * OS + i];
      model[NTE + NCR + g] = x;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [L-1:0] imgs [3];
    logic [NOB-1:0] nets [3];
    imgs[0] = 10'b00_01_101101;  // obs, ctl(ctl1=0,ctl0=1), tpe
    imgs[1] = 10'b00_10_010011;
    imgs[2] = 10'b00_11_111111;
    nets[0] = 12'h0F1;   // grp0 xor=1 (5 ones), grp1 0
    nets[1] = 12'h503;   // grp0 0, grp1 0
    nets[2] = 12'h781;   // grp0 0 (2 ones), grp1 1

    test_mode = 1; ct_din = 6'b101010;
    #(PERIOD * 2 + 1);
    check(scan_out == 0, "R1 scan_out in reset", 32'(scan_out), 0);
    check(ct_dout == ct_din, "R1 gated pass in reset", 32'(ct_dout), 32'(ct_din));
    @(negedge tp_clk); tp_rst_n = 1;

    // R9 bypass under several patterns
    test_mode = 0;
    for (int k = 0; k < 3; k++) begin
      f0_din = 2'(k + 1); f1_din = 2'(k); fr_din = 4'(5 * k + 3); ct_din = 6'(11 * k + 7);
      #1;
      check({f0_dout, f1_dout, fr_dout, ct_dout} == {f0_din, f1_din, fr_din, ct_din},
            "R9 bypass", 32'({f0_dout, f1_dout, fr_dout, ct_dout}),
            32'({f0_din, f1_din, fr_din, ct_din}));
    end

    // R2 constants
    test_mode = 1; f0_din = '1; f1_din = '0; #1;
    check(f0_dout == '0, "R2 force low", 32'(f0_dout), 0);
    check(f1_dout == '1, "R2 force high", 32'(f1_dout), 3);

    for (int p = 0; p < 3; p++) begin
      test_mode = 1;
      shift_image(imgs[p]);
      @(negedge tp_clk); scan_enable = 0;
      fr_din = 4'b0101; ct_din = ~6'(p * 9);
      #1;
      check(fr_dout == fr_expect(model), "R3 register point", 32'(fr_dout), 32'(fr_expect(model)));
      check(ct_dout == ct_expect(model), "R4 R7 gated point", 32'(ct_dout), 32'(ct_expect(model)));
      test_mode = 0; #1;
      check(ct_dout == ct_din && fr_dout == fr_din, "R9 regs ignored",
            32'({ct_dout, fr_dout}), 32'({ct_din, fr_din}));
      test_mode = 1;
      capture(nets[p]);
      #1;
      check(ct_dout == ct_expect(model), "R6 control held", 32'(ct_dout), 32'(ct_expect(model)));
    end
    shift_image('0);   // unload last capture through scoreboard
    #(PERIOD);
    check(exp_q.size() == 0, "R5 queue drained", 32'(exp_q.size()), 0);

    // R1 again: reset mid-state clears chain
    shift_image(10'b11_11_111111);
    @(negedge tp_clk); scan_enable = 0; tp_rst_n = 0; #1;
    model = '0;
    check(scan_out == 0 && ct_dout == ct_din, "R1 reset clears", 32'(scan_out), 0);
    @(negedge tp_clk); tp_rst_n = 1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule